// File: doc/BRIEF.md
# Latched Seven-Segment Digit Decoder with Ripple Blanking

This block sits behind a decimal counter digit. A strobe decides whether its holding register keeps tracking the incoming BCD value or freezes the value currently shown, so the counter can keep running while an earlier reading stays on display. The held value is made available in binary-weighted form for other logic. It is also decoded into seven active-high segment drives and a decimal-point drive.

Digits are chained through an active-low ripple-blank path. A digit that holds zero and sees its ripple-blank input low goes dark and pulls its ripple-blank output low, so the next digit can suppress its own zero in turn. This is how leading or trailing zeros are hidden. An overriding blank input darkens the digit and also pulls the ripple line low. It can be pulsed to dim the digit.

The ripple-blank output is modelled as a wired-AND node. The block's own drive is ANDed with an external active-low node input, and any low on the node darkens the digit. The node can therefore double as a blanking input from outside.

Top module: `seg_digit_display`

## Requirements
- R1: While `strobe_i` is low at a rising clock edge, the held value takes `bcd_i`, and `held_o` shows it one cycle later.
- R2: While `strobe_i` is high at a rising clock edge, the held value does not change, whatever `bcd_i` does.
- R3: `held_o` carries the held value with bit 0 weighted 1, bit 1 weighted 2, bit 2 weighted 4 and bit 3 weighted 8.
- R4: When not blanked, `seg_o` (bit 0 = segment a through bit 6 = segment g) shows these patterns: 0 = 0x3F, 1 = 0x06, 2 = 0x5B, 3 = 0x4F, 4 = 0x66, 5 = 0x6D, 6 = 0x7D, 7 = 0x07, 8 = 0x7F, 9 = 0x6F. Values 10 to 15 show 0x00.
- R5: While `blank_i` is high, `seg_o` is 0, `dp_o` is 0 and `rb_n_o` is 0, whatever the held value and `rbi_n_i` are.
- R6: While `rbi_n_i` is low and the held value is 0, the digit is dark (`seg_o` = 0, `dp_o` = 0) and `rb_n_o` is 0.
- R7: While the held value is not 0, `rbi_n_i` has no effect: `rb_n_o` stays 1 and `seg_o` shows the digit, provided `blank_i` is low and `rb_node_n_i` is high.
- R8: While `rb_node_n_i` is low, `rb_n_o` is 0 and the digit is fully dark.
- R9: `dp_o` is 1 exactly when `dp_req_i` is 1 and the digit is not blanked.
- R10: Asynchronous reset (`rst_ni` low) clears the held value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bcd_i | input | 4 | BCD value from the counter |
| strobe_i | input | 1 | High holds the value, low tracks `bcd_i` |
| blank_i | input | 1 | Overriding blank, active high |
| rbi_n_i | input | 1 | Ripple-blank input, active low |
| dp_req_i | input | 1 | Decimal point request |
| rb_node_n_i | input | 1 | External pull on the wired ripple node, active low |
| held_o | output | 4 | Held value, binary weighted |
| seg_o | output | 7 | Segment drives a..g, active high |
| dp_o | output | 1 | Decimal point drive |
| rb_n_o | output | 1 | Ripple-blank node value, active low |

## Verification
The bench builds the block with its defaults: a 4-bit digit and a reset value of 0. With these values every code from 0 to 15 can be loaded and its decoded pattern checked, including the six codes above 9 that must leave the display dark. Because the reset value is zero, the bench can also reach the zero-suppression case straight out of reset. From there it walks through each blanking source on its own and in combination, with the decimal point requested, to show which source wins and what the ripple output does.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_N   = 7;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_t;

  // bit 0 = a .. bit 6 = g
  function automatic seg_t seg_encode(input digit_t v);
    seg_t s;
    unique case (v)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sdd_hold_reg.sv
module sdd_hold_reg #(
  parameter int unsigned W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // clocked register replaces a transparent latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= RST_VAL;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/sdd_blank_ctl.sv
module sdd_blank_ctl #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] val_i,
  input  logic         blank_i,
  input  logic         rbi_n_i,
  input  logic         node_n_i,
  output logic         rb_n_o,
  output logic         dark_o
);
  logic is_zero;
  logic own_drive;

  assign is_zero   = ~|val_i;
  assign own_drive = ~(blank_i | (~rbi_n_i & is_zero));
  // wired-AND with external pull
  assign rb_n_o    = own_drive & node_n_i;
  assign dark_o    = ~rb_n_o;
endmodule

// File: rtl/sdd_seg_decode.sv
module sdd_seg_decode
  import seg_disp_pkg::*;
(
  input  digit_t val_i,
  input  logic   dark_i,
  input  logic   dp_req_i,
  output seg_t   seg_o,
  output logic   dp_o
);
  seg_t raw;

  assign raw = seg_encode(val_i);

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg_o[i] = raw[i] & ~dark_i;
  end

  assign dp_o = dp_req_i & ~dark_i;
endmodule

// File: rtl/seg_digit_display.sv
module seg_digit_display
  import seg_disp_pkg::*;
#(
  parameter digit_t RST_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIGIT_W-1:0] bcd_i,
  input  logic               strobe_i,
  input  logic               blank_i,
  input  logic               rbi_n_i,
  input  logic               dp_req_i,
  input  logic               rb_node_n_i,
  output logic [DIGIT_W-1:0] held_o,
  output logic [SEG_N-1:0]   seg_o,
  output logic               dp_o,
  output logic               rb_n_o
);
  digit_t held_q;
  logic   dark;

  sdd_hold_reg #(.W(DIGIT_W), .RST_VAL(RST_VAL)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (strobe_i),
    .d_i    (bcd_i),
    .q_o    (held_q)
  );

  sdd_blank_ctl #(.W(DIGIT_W)) u_blank (
    .val_i    (held_q),
    .blank_i  (blank_i),
    .rbi_n_i  (rbi_n_i),
    .node_n_i (rb_node_n_i),
    .rb_n_o   (rb_n_o),
    .dark_o   (dark)
  );

  sdd_seg_decode u_dec (
    .val_i    (held_q),
    .dark_i   (dark),
    .dp_req_i (dp_req_i),
    .seg_o    (seg_o),
    .dp_o     (dp_o)
  );

  assign held_o = held_q;
endmodule

// File: rtl/seg_digit_display_chk.sv
module seg_digit_display_chk
  import seg_disp_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DIGIT_W-1:0] bcd_i,
  input logic               strobe_i,
  input logic               blank_i,
  input logic               rbi_n_i,
  input logic               dp_req_i,
  input logic               rb_node_n_i,
  input logic [DIGIT_W-1:0] held_o,
  input logic [SEG_N-1:0]   seg_o,
  input logic               dp_o,
  input logic               rb_n_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  track_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !strobe_i) |=> (held_o == $past(bcd_i)));

  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && strobe_i) |=> $stable(held_o));

  // R5
  blank_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> (seg_o == '0 && !dp_o && !rb_n_o));

  // R6
  zero_suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rbi_n_i && held_o == '0) |-> (seg_o == '0 && !rb_n_o));

  // R7
  rbi_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o != '0 && !blank_i && rb_node_n_i) |-> rb_n_o);

  // R8
  node_low_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb_node_n_i |-> (!rb_n_o && seg_o == '0 && !dp_o));

  // R9
  dp_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_o |-> (dp_req_i && rb_n_o));
endmodule

bind seg_digit_display seg_digit_display_chk u_chk (.*);

// File: tb/seg_digit_display_tb.sv
module seg_digit_display_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bcd = '0;
  logic       strobe = 1'b0;
  logic       blank = 1'b0;
  logic       rbi_n = 1'b1;
  logic       dp_req = 1'b0;
  logic       node_n = 1'b1;
  logic [3:0] held;
  logic [6:0] seg;
  logic       dp;
  logic       rb_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_digit_display dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bcd_i(bcd), .strobe_i(strobe),
    .blank_i(blank), .rbi_n_i(rbi_n), .dp_req_i(dp_req),
    .rb_node_n_i(node_n), .held_o(held), .seg_o(seg), .dp_o(dp),
    .rb_n_o(rb_n)
  );

  function automatic logic [6:0] exp_seg(input int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // load value with strobe low, return with outputs settled
  task automatic load(input int v);
    strobe = 1'b0;
    bcd = v[3:0];
    @(posedge clk); #2;
  endtask

  task automatic t_reset;
    check("R10 held after reset", held, 0);
    check("R10 seg after reset", seg, 7'h3F);
    check("R10 rb after reset", rb_n, 1);
  endtask

  task automatic t_decode;
    for (int v = 0; v < 16; v++) begin
      load(v);
      check("R1 held tracks bcd", held, v);
      check("R4 segment pattern", seg, exp_seg(v));
    end
    load(4'b1010);
    check("R3 bit weights", {held[3], held[2], held[1], held[0]}, 10);
  endtask

  task automatic t_hold;
    load(7);
    strobe = 1'b1;
    for (int v = 0; v < 4; v++) begin
      bcd = v[3:0];
      @(posedge clk); #2;
      check("R2 held frozen", held, 7);
      check("R2 seg frozen", seg, 7'h07);
    end
    strobe = 1'b0;
    @(posedge clk); #2;
    check("R1 resume tracking", held, 3);
  endtask

  task automatic t_blank;
    load(8);
    dp_req = 1'b1; blank = 1'b1; #1;
    check("R5 seg off", seg, 0);
    check("R5 dp off", dp, 0);
    check("R5 rb low", rb_n, 0);
    load(0); rbi_n = 1'b1; #1;
    check("R5 zero held rb low", rb_n, 0);
    blank = 1'b0; #1;
    check("R9 dp lit when shown", dp, 1);
    dp_req = 1'b0;
  endtask

  task automatic t_ripple;
    load(0);
    rbi_n = 1'b1; #1;
    check("R6 zero shown rbi high", seg, 7'h3F);
    check("R6 rb high rbi high", rb_n, 1);
    dp_req = 1'b1;
    rbi_n = 1'b0; #1;
    check("R6 zero suppressed", seg, 0);
    check("R6 rb low", rb_n, 0);
    check("R9 dp off when suppressed", dp, 0);
    load(5);
    check("R7 rbi ignored seg", seg, 7'h6D);
    check("R7 rbi ignored rb", rb_n, 1);
    check("R9 dp lit", dp, 1);
    rbi_n = 1'b1; dp_req = 1'b0;
  endtask

  task automatic t_node;
    load(2);
    dp_req = 1'b1;
    node_n = 1'b0; #1;
    check("R8 node low seg", seg, 0);
    check("R8 node low dp", dp, 0);
    check("R8 node low rb", rb_n, 0);
    node_n = 1'b1; #1;
    check("R8 node released", seg, 7'h5B);
    dp_req = 1'b0; #1;
    check("R9 dp off without req", dp, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_decode();
    t_hold();
    t_blank();
    t_ripple();
    t_node();
    rst_n = 1'b0; #1;
    check("R10 async clear", held, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule